// File: doc/BRIEF.md
# Dual Halfword Multiply-Combine Unit

This block treats each of its two word operands as a pair of signed halfwords. It forms two signed products: lower halfword by lower halfword, and upper by upper. It then adds the two products, or subtracts the upper product from the lower one. The combined value can pass through unchanged. It can also be added to a 32-bit accumulator and kept as a 32-bit result, or added to a 64-bit accumulator and kept as a 64-bit result. An exchange control swaps the two halfwords of the second operand before the multiplies. This pairs real and imaginary parts of complex samples and suits filter kernels.

The unit has two pipeline stages. The multiplies are registered in the first stage, and the combine and accumulate are registered in the second. A valid bit travels with each operation, and a new operation may enter on every cycle. Results wrap in two's complement. A sticky overflow flag records that a 32-bit form produced a mathematically exact value outside the signed 32-bit range. The flag stays set until the clear input is raised.

Top module: `dual_hmac`

## Requirements
- R1: With `op_sub`=0, `op_acc`=0 and `op_long`=0, `result[31:0]` is (opa[15:0]×opb[15:0] + opa[31:16]×opb[31:16]) modulo 2^32, with all operands signed, and `result[63:32]` copies bit 31.
- R2: With `op_sub`=1, the combined value is the lower-halfword product minus the upper-halfword product.
- R3: With `op_swap`=1, opb[31:16] and opb[15:0] trade places before both multiplies.
- R4: With `op_acc`=1 and `op_long`=0, the signed value of `acc[31:0]` is added to the combined value and the sum wraps to 32 bits. `acc[63:32]` has no effect.
- R5: With `op_long`=1, `result` is the combined value sign-extended to 64 bits, plus `acc` when `op_acc`=1, taken modulo 2^64.
- R6: `out_valid` and the matching `result` appear two rising edges after the edge that samples `in_valid`=1. Operations may be issued on every cycle.
- R7: `result` holds its last value while `out_valid` is 0.
- R8: A 32-bit form whose exact value lies outside [-2^31, 2^31-1] sets `q_flag`, updated together with its result. This includes the no-accumulate add where both products equal (-32768)².
- R9: A 64-bit form never sets `q_flag`.
- R10: `q_flag` stays set until an edge samples `q_clear`=1. An overflow completing on that same edge leaves it set.
- R11: While `rst_n` is low, `out_valid`, `q_flag` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| opa | input | 32 | First operand, two signed halfwords |
| opb | input | 32 | Second operand, two signed halfwords |
| acc | input | 64 | Accumulator; low 32 bits used in the 32-bit forms |
| op_sub | input | 1 | 1: lower product minus upper product |
| op_acc | input | 1 | 1: add the accumulator |
| op_long | input | 1 | 1: 64-bit form |
| op_swap | input | 1 | 1: swap the halfwords of opb |
| q_clear | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result present |
| result | output | 64 | Result; 32-bit forms are sign-extended |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
An operation driven just after a falling edge is sampled on the next rising edge. Its result, `out_valid` and any `q_flag` update appear after the rising edge that follows. The bench therefore drives all inputs on falling edges and compares outputs on the falling edge two periods after the drive. It keeps a two-entry record of issued operations so that each comparison uses the right one. A `q_clear` is applied one edge after its drive, so the bench's flag model applies the clear driven one period earlier, together with the overflow of the operation driven two periods earlier.

// File: rtl/dual_hmac_pkg.sv
package dual_hmac_pkg;
   typedef struct packed {
      logic sub;
      logic acc;
      logic lng;
   } dhm_ctrl_t;
endpackage

// File: rtl/dual_hmac_mul_stage.sv
module dual_hmac_mul_stage
   import dual_hmac_pkg::*;
#(
   parameter int HALF_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [2*HALF_W-1:0]      opa,
   input  logic [2*HALF_W-1:0]      opb,
   input  logic [4*HALF_W-1:0]      acc_in,
   input  logic                     swap,
   input  dhm_ctrl_t                ctrl_in,
   output logic                     s1_valid,
   output logic signed [2*HALF_W-1:0] s1_prod_lo,
   output logic signed [2*HALF_W-1:0] s1_prod_hi,
   output logic [4*HALF_W-1:0]      s1_acc,
   output dhm_ctrl_t                s1_ctrl
);
   localparam int WORD_W = 2 * HALF_W;
   localparam int PROD_W = 2 * HALF_W;
   localparam int LONG_W = 4 * HALF_W;
   localparam int LANES  = 2;

   if (HALF_W < 2) begin : g_bad_width
      $error("dual_hmac_mul_stage: HALF_W must be at least 2");
   end

   logic [WORD_W-1:0]        b_sel;
   logic signed [PROD_W-1:0] prod_c [LANES];
   logic signed [PROD_W-1:0] prod_q [LANES];

   assign b_sel = swap ? {opb[HALF_W-1:0], opb[WORD_W-1:HALF_W]} : opb;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic signed [PROD_W-1:0] xa;
      logic signed [PROD_W-1:0] xb;
      assign xa = PROD_W'($signed(opa[g*HALF_W +: HALF_W]));
      assign xb = PROD_W'($signed(b_sel[g*HALF_W +: HALF_W]));
      assign prod_c[g] = xa * xb;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod_q[g] <= '0;
         end else if (in_valid) begin
            prod_q[g] <= prod_c[g];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_acc   <= '0;
         s1_ctrl  <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_acc  <= acc_in;
            s1_ctrl <= ctrl_in;
         end
      end
   end

   assign s1_prod_lo = prod_q[0];
   assign s1_prod_hi = prod_q[1];

   logic unused_w;
   assign unused_w = ^LONG_W;
endmodule

// File: rtl/dual_hmac_sum_stage.sv
module dual_hmac_sum_stage
   import dual_hmac_pkg::*;
#(
   parameter int HALF_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       q_clear,
   input  logic                       s1_valid,
   input  logic signed [2*HALF_W-1:0] s1_prod_lo,
   input  logic signed [2*HALF_W-1:0] s1_prod_hi,
   input  logic [4*HALF_W-1:0]        s1_acc,
   input  dhm_ctrl_t                  s1_ctrl,
   output logic                       out_valid,
   output logic [4*HALF_W-1:0]        result,
   output logic                       q_flag
);
   localparam int PROD_W = 2 * HALF_W;
   localparam int WORD_W = 2 * HALF_W;
   localparam int LONG_W = 4 * HALF_W;
   localparam int CMB_W  = PROD_W + 1;
   localparam int SHT_W  = WORD_W + 2;
   localparam int TOP_N  = SHT_W - WORD_W + 1;

   if (HALF_W < 2) begin : g_bad_width
      $error("dual_hmac_sum_stage: HALF_W must be at least 2");
   end

   logic signed [CMB_W-1:0] cmb;
   logic signed [SHT_W-1:0] acc_short;
   logic signed [SHT_W-1:0] sht;
   logic [LONG_W-1:0]       acc_long;
   logic [LONG_W-1:0]       lsum;
   logic [TOP_N-1:0]        sht_top;
   logic                    ovf_short;
   logic                    ovf_event;
   logic [LONG_W-1:0]       res_n;

   always_comb begin
      if (s1_ctrl.sub) begin
         cmb = CMB_W'(s1_prod_lo) - CMB_W'(s1_prod_hi);
      end else begin
         cmb = CMB_W'(s1_prod_lo) + CMB_W'(s1_prod_hi);
      end
   end

   assign acc_short = s1_ctrl.acc ? SHT_W'($signed(s1_acc[WORD_W-1:0])) : '0;
   assign sht       = SHT_W'(cmb) + acc_short;
   assign sht_top   = sht[SHT_W-1:WORD_W-1];
   assign ovf_short = ~((&sht_top) | ~(|sht_top));

   assign acc_long  = s1_ctrl.acc ? s1_acc : '0;
   assign lsum      = LONG_W'(cmb) + acc_long;

   assign res_n     = s1_ctrl.lng ? lsum
                                  : {{(LONG_W-WORD_W){sht[WORD_W-1]}}, sht[WORD_W-1:0]};
   assign ovf_event = s1_valid & ~s1_ctrl.lng & ovf_short;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         q_flag    <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            result <= res_n;
         end
         q_flag <= (q_flag & ~q_clear) | ovf_event;
      end
   end
endmodule

// File: rtl/dual_hmac.sv
module dual_hmac
   import dual_hmac_pkg::*;
#(
   parameter int HALF_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [2*HALF_W-1:0]   opa,
   input  logic [2*HALF_W-1:0]   opb,
   input  logic [4*HALF_W-1:0]   acc,
   input  logic                  op_sub,
   input  logic                  op_acc,
   input  logic                  op_long,
   input  logic                  op_swap,
   input  logic                  q_clear,
   output logic                  out_valid,
   output logic [4*HALF_W-1:0]   result,
   output logic                  q_flag
);
   localparam int PROD_W = 2 * HALF_W;
   localparam int LONG_W = 4 * HALF_W;

   if (HALF_W < 2) begin : g_bad_width
      $error("dual_hmac: HALF_W must be at least 2");
   end

   dhm_ctrl_t                ctrl_in;
   dhm_ctrl_t                s1_ctrl;
   logic                     s1_valid;
   logic signed [PROD_W-1:0] s1_prod_lo;
   logic signed [PROD_W-1:0] s1_prod_hi;
   logic [LONG_W-1:0]        s1_acc;

   assign ctrl_in.sub = op_sub;
   assign ctrl_in.acc = op_acc;
   assign ctrl_in.lng = op_long;

   dual_hmac_mul_stage #(.HALF_W(HALF_W)) u_mul (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .opa        (opa),
      .opb        (opb),
      .acc_in     (acc),
      .swap       (op_swap),
      .ctrl_in    (ctrl_in),
      .s1_valid   (s1_valid),
      .s1_prod_lo (s1_prod_lo),
      .s1_prod_hi (s1_prod_hi),
      .s1_acc     (s1_acc),
      .s1_ctrl    (s1_ctrl)
   );

   dual_hmac_sum_stage #(.HALF_W(HALF_W)) u_sum (
      .clk        (clk),
      .rst_n      (rst_n),
      .q_clear    (q_clear),
      .s1_valid   (s1_valid),
      .s1_prod_lo (s1_prod_lo),
      .s1_prod_hi (s1_prod_hi),
      .s1_acc     (s1_acc),
      .s1_ctrl    (s1_ctrl),
      .out_valid  (out_valid),
      .result     (result),
      .q_flag     (q_flag)
   );
endmodule

// File: rtl/dual_hmac_chk.sv
module dual_hmac_chk #(
   parameter int HALF_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                op_long,
   input logic                q_clear,
   input logic                out_valid,
   input logic [4*HALF_W-1:0] result,
   input logic                q_flag
);
   localparam int WORD_W = 2 * HALF_W;
   localparam int LONG_W = 4 * HALF_W;

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R6

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && !out_valid) |-> $stable(result)); // R7

   AST_Q_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_flag) |-> out_valid); // R8

   AST_LONG_NO_Q: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $rose(q_flag)) |-> $past(!op_long, 2)); // R9

   AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (q_flag && !q_clear) |=> q_flag); // R10

   AST_Q_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && $past(q_clear) && !out_valid) |-> !q_flag); // R10

   AST_SHORT_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && out_valid && $past(!op_long, 2))
         |-> (result[LONG_W-1:WORD_W] == {(LONG_W-WORD_W){result[WORD_W-1]}})); // R1
endmodule

bind dual_hmac dual_hmac_chk #(.HALF_W(HALF_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_long   (op_long),
   .q_clear   (q_clear),
   .out_valid (out_valid),
   .result    (result),
   .q_flag    (q_flag)
);

// File: tb/dual_hmac_test.sv
module dual_hmac_test;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, in_valid, op_sub, op_acc, op_long, op_swap, q_clear;
   logic [31:0] opa, opb;
   logic [63:0] acc;
   logic        out_valid, q_flag;
   logic [63:0] result;

   dual_hmac #(.HALF_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb), .acc(acc),
      .op_sub(op_sub), .op_acc(op_acc), .op_long(op_long), .op_swap(op_swap),
      .q_clear(q_clear), .out_valid(out_valid), .result(result), .q_flag(q_flag)
   );

   typedef struct {
      bit          v;
      logic [31:0] a, b;
      logic [63:0] c;
      bit          sub, ac, lg, sw, clr;
   } stim_t;

   int checks = 0, fails = 0;
   bit done = 0;
   stim_t d1, d2, zs;
   bit mq;
   logic [63:0] last_r;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic void model(input stim_t s, output logic [63:0] r, output bit ovf);
      logic [31:0] bs;
      longint plo, phi, cmb, t;
      bs  = s.sw ? {s.b[15:0], s.b[31:16]} : s.b;
      plo = longint'($signed(s.a[15:0])) * longint'($signed(bs[15:0]));
      phi = longint'($signed(s.a[31:16])) * longint'($signed(bs[31:16]));
      cmb = s.sub ? plo - phi : plo + phi;
      if (s.lg) begin
         r   = 64'(cmb) + (s.ac ? s.c : 64'd0);
         ovf = 1'b0;
      end else begin
         t   = cmb + (s.ac ? longint'($signed(s.c[31:0])) : 64'sd0);
         ovf = (t > 64'sd2147483647) || (t < -64'sd2147483648);
         r   = {{32{t[31]}}, t[31:0]};
      end
   endfunction

   function automatic string tag_of(input stim_t s);
      if (s.lg) return "R5 long";
      if (s.ac) return "R4 acc32";
      if (s.sw) return "R3 swap";
      if (s.sub) return "R2 sub";
      return "R1 add";
   endfunction

   task automatic step(input stim_t s);
      logic [63:0] r;
      bit o;
      @(negedge clk);
      chk("R6 out_valid", {63'd0, out_valid}, {63'd0, d2.v});
      o = 1'b0;
      if (d2.v) begin
         model(d2, r, o);
         chk(tag_of(d2), result, r);
         last_r = r;
      end else begin
         chk("R7 hold", result, last_r);
      end
      mq = (mq & ~d1.clr) | (d2.v & o);
      chk("R8 R9 R10 q_flag", {63'd0, q_flag}, {63'd0, mq});
      in_valid = s.v; opa = s.a; opb = s.b; acc = s.c;
      op_sub = s.sub; op_acc = s.ac; op_long = s.lg; op_swap = s.sw; q_clear = s.clr;
      d2 = d1; d1 = s;
   endtask

   function automatic stim_t mk(input bit v, input logic [31:0] a, input logic [31:0] b,
                                input logic [63:0] c, input bit sub, input bit ac,
                                input bit lg, input bit sw, input bit clr);
      stim_t s;
      s.v = v; s.a = a; s.b = b; s.c = c; s.sub = sub; s.ac = ac; s.lg = lg; s.sw = sw; s.clr = clr;
      return s;
   endfunction

   function automatic logic [15:0] pick_half();
      case ($urandom % 6)
         0: return 16'h8000;
         1: return 16'h7fff;
         2: return 16'h0000;
         3: return 16'hffff;
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      zs = mk(0, 0, 0, 0, 0, 0, 0, 0, 0);
      d1 = zs; d2 = zs; mq = 0; last_r = '0;
      rst_n = 0; in_valid = 0; opa = 0; opb = 0; acc = 0;
      op_sub = 0; op_acc = 0; op_long = 0; op_swap = 0; q_clear = 0;
      repeat (3) @(negedge clk);
      chk("R11 reset out_valid", {63'd0, out_valid}, 64'd0);
      chk("R11 reset q_flag", {63'd0, q_flag}, 64'd0);
      chk("R11 reset result", result, 64'd0);
      rst_n = 1;

      // R8: both products (-32768)^2 with plain add overflows
      step(mk(1, 32'h80008000, 32'h80008000, 0, 0, 0, 0, 0, 0));
      step(zs); step(zs);
      step(mk(0, 0, 0, 0, 0, 0, 0, 0, 1)); // R10 clear
      step(zs); step(zs);
      // R9: same operands in the 64-bit form, no flag
      step(mk(1, 32'h80008000, 32'h80008000, 0, 0, 0, 1, 0, 0));
      // R2 subtract, R3 swap, R4 with junk in acc[63:32]
      step(mk(1, 32'h00030005, 32'h00020007, 0, 1, 0, 0, 0, 0));
      step(mk(1, 32'h00030005, 32'h00020007, 0, 0, 0, 0, 1, 0));
      step(mk(1, 32'h00030005, 32'h00020007, 64'hDEADBEEF00000010, 0, 1, 0, 0, 0));
      // R8 accumulate overflow, then R10 clear on the edge of another overflow
      step(mk(1, 32'h7fff7fff, 32'h7fff7fff, 64'h000000007fffffff, 0, 1, 0, 0, 0));
      step(mk(1, 32'h80007fff, 32'h7fff7fff, 64'h0000000080000000, 1, 1, 0, 0, 1));
      step(mk(0, 0, 0, 0, 0, 0, 0, 0, 1));
      // R5 long accumulate near the 64-bit edge
      step(mk(1, 32'h7fff8000, 32'h80008000, 64'h7fffffffffffffff, 0, 1, 1, 1, 0));
      step(mk(1, 32'h12345678, 32'h9abcdef0, 64'h8000000000000000, 1, 1, 1, 0, 0));
      step(zs); step(zs); step(zs);

      for (int i = 0; i < 6000; i++) begin
         stim_t s;
         s.v   = ($urandom % 4) != 0;
         s.a   = {pick_half(), pick_half()};
         s.b   = {pick_half(), pick_half()};
         s.c   = ($urandom % 3 == 0) ? {32'($urandom), 32'h7fffffff} : {32'($urandom), 32'($urandom)};
         s.sub = $urandom % 2; s.ac = $urandom % 2; s.lg = ($urandom % 3) == 0;
         s.sw  = $urandom % 2; s.clr = ($urandom % 16) == 0;
         step(s);
      end
      step(zs); step(zs); step(zs);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule